// File: doc/BRIEF.md
# Stack Call and Jump Sequencer

This block is the multi-cycle control slice of a small 8-bit processor that handles control transfer. It owns the 16-bit program counter, the upward-growing byte stack pointer and two 16-bit pointer registers, P and Q. It runs absolute jumps, jumps that leave a link address in Q, subroutine calls that keep their return address on the memory stack, the matching return, and short relative branches that depend on a zero flag. The instruction is fetched elsewhere. When an opcode reaches this block, the program counter already points at the byte after the opcode. Operand bytes are read at the program counter, which moves past each one as it is read.

Opcodes arrive on a valid/ready stream. The sequencer accepts an opcode in a cycle where `op_valid` and `op_ready` are both high, and that cycle is the first cycle of the instruction. `op_ready` stays low for the rest of a multi-cycle instruction. While `op_valid` is high and `op_ready` is low, the source must hold `op_code` steady. `done` pulses on the last cycle of every instruction. Memory is a single-port synchronous byte array. A read issued in one cycle returns its data on `mem_rdata` in the next cycle, and a write takes effect at the clock edge that ends its request cycle. The rest of the processor preloads the four registers through a plain load port, which acts only when the sequencer is idle.

Top module: `callseq_unit`

## Requirements
- R1: After reset, I, S, P and Q are zero, `op_ready` is high, and `done` and `mem_req` are low.
- R2: `done` is high for exactly one cycle per accepted opcode, on its last cycle. `op_ready` is low from the cycle after a multi-cycle opcode is accepted up to and including its `done` cycle, and is high in the next cycle.
- R3: Cycle counts from acceptance to `done`, inclusive: 0x60 and 0x63 take 3; 0x64 to 0x67 take 1; 0xE2 takes 5; 0xE4, 0xE5 and 0xE1 take 3; 0x30, 0x31 and 0x32 take 2; any other opcode takes 1.
- R4: 0x60 reads the low operand byte at I and the high byte at I+1, then sets I to the 16-bit operand. 0x63 does the same and also loads Q with the address after the operand bytes. Neither opcode writes memory.
- R5: 0x64 sets I to P and 0x66 sets I to Q. 0x65 and 0x67 make the same jump and also load Q with the old I, so 0x67 exchanges I and Q.
- R6: The call opcodes are 0xE2 (operand target), 0xE4 (target P) and 0xE5 (target Q). Each writes R-1 to memory, where R is the address after the instruction's bytes. The high byte goes to address S and the low byte to S+1, in that order. S ends 2 higher, and I is then set to the target.
- R7: 0xE1 reads the low byte at S-1 and then the high byte at S-2. S ends 2 lower, and I becomes the 16-bit value read plus one, with carry into the high byte.
- R8: 0x30, 0x31 and 0x32 read a signed offset byte at I and advance I past it. In the second cycle they add the sign-extended offset to I: 0x31 always, 0x30 when `zflag` is low, and 0x32 when `zflag` is high. `zflag` is sampled in the second cycle.
- R9: The block issues at most one memory access per cycle and none while it is idle.
- R10: Any opcode not listed above completes in one cycle and changes no register and no memory.
- R11: `ld_en` writes `ld_data` into the register chosen by `ld_sel` (0 is I, 1 is S, 2 is P, 3 is Q). The write happens only when `op_ready` is high and `op_valid` is low; in any other cycle `ld_en` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode stream valid |
| op_ready | output | 1 | Opcode stream ready (sequencer idle) |
| op_code | input | 8 | Opcode to execute |
| zflag | input | 1 | Zero flag for conditional branches |
| ld_en | input | 1 | Register preload strobe |
| ld_sel | input | 2 | Preload target: 0 I, 1 S, 2 P, 3 Q |
| ld_data | input | 16 | Preload value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| done | output | 1 | Last cycle of the current instruction |
| reg_i | output | 16 | Program counter |
| reg_s | output | 16 | Stack pointer |
| reg_p | output | 16 | Pointer register P |
| reg_q | output | 16 | Pointer register Q |

## Verification
The hardest case to reach is a return whose byte arithmetic carries across both bytes. A call must push an address whose low byte borrows when one is subtracted, and the return must then add the one back with a carry into the high byte. The stimulus preloads I with a value whose low byte is zero, calls through P and returns. The bench also nests a register call inside an operand call and unwinds both, so each pop must read the bytes the matching push wrote. Load strobes are raised during a busy cycle and together with a valid opcode, to show they change nothing.

// File: rtl/callseq_pkg.sv
package callseq_pkg;

  localparam int STEP_W = 3;

  typedef enum logic [3:0] {
    K_NOP, K_JMP_IMM, K_LNK_IMM, K_JMP_P, K_LNK_P, K_JMP_Q, K_LNK_Q,
    K_CALL_IMM, K_CALL_P, K_CALL_Q, K_RET, K_BR_NZ, K_BR_Z, K_BR_ALW
  } op_kind_t;

  // where the program counter is loaded from in a given step
  typedef enum logic [2:0] {
    T_NONE, T_OPND, T_SAVED, T_RET, T_P, T_Q, T_REL
  } tgt_t;

  typedef struct packed {
    logic rd_opnd;  // read byte at I, advance I
    logic cap_lo;   // latch read data as low byte
    logic cap_hi;   // latch read data as high byte
    logic push_hi;  // write high byte of I-1 at S, S+1
    logic push_lo;  // write low byte of I-1 at S, S+1
    logic pop;      // S-1, read at S-1
    logic link;     // Q takes the current I
    tgt_t tgt;
  } uop_t;

  function automatic logic [STEP_W-1:0] final_step(input op_kind_t k);
    case (k)
      K_JMP_IMM, K_LNK_IMM, K_CALL_P, K_CALL_Q, K_RET: return STEP_W'(2);
      K_CALL_IMM:                                      return STEP_W'(4);
      K_BR_NZ, K_BR_Z, K_BR_ALW:                       return STEP_W'(1);
      default:                                         return STEP_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/callseq_decode.sv
module callseq_decode
  import callseq_pkg::*;
(
  input  logic [7:0] op_code,
  output op_kind_t   kind
);
  always_comb begin
    case (op_code)
      8'h60:   kind = K_JMP_IMM;
      8'h63:   kind = K_LNK_IMM;
      8'h64:   kind = K_JMP_P;
      8'h65:   kind = K_LNK_P;
      8'h66:   kind = K_JMP_Q;
      8'h67:   kind = K_LNK_Q;
      8'hE2:   kind = K_CALL_IMM;
      8'hE4:   kind = K_CALL_P;
      8'hE5:   kind = K_CALL_Q;
      8'hE1:   kind = K_RET;
      8'h30:   kind = K_BR_NZ;
      8'h31:   kind = K_BR_ALW;
      8'h32:   kind = K_BR_Z;
      default: kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/callseq_ucode.sv
module callseq_ucode
  import callseq_pkg::*;
(
  input  logic              en,
  input  op_kind_t          kind,
  input  logic [STEP_W-1:0] step,
  input  logic              zflag,
  output uop_t              uop
);
  logic taken;

  always_comb begin
    case (kind)
      K_BR_NZ: taken = !zflag;
      K_BR_Z:  taken = zflag;
      default: taken = 1'b1;
    endcase
  end

  always_comb begin
    uop = '0;
    if (en) begin
      case (kind)
        K_JMP_IMM, K_LNK_IMM: begin
          case (step)
            STEP_W'(0): uop.rd_opnd = 1'b1;
            STEP_W'(1): begin uop.rd_opnd = 1'b1; uop.cap_lo = 1'b1; end
            default: begin
              uop.tgt  = T_OPND;
              uop.link = (kind == K_LNK_IMM);
            end
          endcase
        end
        K_JMP_P: uop.tgt = T_P;
        K_LNK_P: begin uop.tgt = T_P; uop.link = 1'b1; end
        K_JMP_Q: uop.tgt = T_Q;
        K_LNK_Q: begin uop.tgt = T_Q; uop.link = 1'b1; end
        K_CALL_IMM: begin
          case (step)
            STEP_W'(0): uop.rd_opnd = 1'b1;
            STEP_W'(1): begin uop.rd_opnd = 1'b1; uop.cap_lo = 1'b1; end
            STEP_W'(2): begin uop.cap_hi = 1'b1; uop.push_hi = 1'b1; end
            STEP_W'(3): uop.push_lo = 1'b1;
            default:    uop.tgt = T_SAVED;
          endcase
        end
        K_CALL_P, K_CALL_Q: begin
          case (step)
            STEP_W'(0): uop.push_hi = 1'b1;
            STEP_W'(1): uop.push_lo = 1'b1;
            default:    uop.tgt = (kind == K_CALL_P) ? T_P : T_Q;
          endcase
        end
        K_RET: begin
          case (step)
            STEP_W'(0): uop.pop = 1'b1;
            STEP_W'(1): begin uop.pop = 1'b1; uop.cap_lo = 1'b1; end
            default:    uop.tgt = T_RET;
          endcase
        end
        K_BR_NZ, K_BR_Z, K_BR_ALW: begin
          if (step == STEP_W'(0)) uop.rd_opnd = 1'b1;
          else if (taken)         uop.tgt = T_REL;
        end
        default: uop = '0;
      endcase
    end
  end
endmodule

// File: rtl/callseq_ctrl.sv
module callseq_ctrl
  import callseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  op_kind_t          kind_in,
  output logic              op_ready,
  output logic              active,
  output op_kind_t          kind_cur,
  output logic [STEP_W-1:0] step_cur,
  output logic              done
);
  logic              busy;
  logic [STEP_W-1:0] step_q;
  op_kind_t          kind_q;
  logic              at_end;

  always_comb begin
    kind_cur = busy ? kind_q : kind_in;
    step_cur = busy ? step_q : '0;
    active   = busy || op_valid;
    at_end   = (step_cur == final_step(kind_cur));
    done     = active && at_end;
    op_ready = !busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step_q <= '0;
      kind_q <= K_NOP;
    end else if (active) begin
      if (at_end) begin
        busy   <= 1'b0;
        step_q <= '0;
      end else begin
        busy   <= 1'b1;
        step_q <= step_cur + STEP_W'(1);
        kind_q <= kind_cur;
      end
    end
  end

  // R2
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> op_ready);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !done) |=> !op_ready);

  // R3
  busy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |-> (step_cur != '0));
endmodule

// File: rtl/callseq_dpath.sv
module callseq_dpath
  import callseq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  uop_t          uop,
  input  logic          ld_fire,
  input  logic [1:0]    ld_sel,
  input  logic [AW-1:0] ld_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW/2-1:0] mem_wdata,
  input  logic [AW/2-1:0] mem_rdata,
  output logic [AW-1:0] reg_i,
  output logic [AW-1:0] reg_s,
  output logic [AW-1:0] reg_p,
  output logic [AW-1:0] reg_q
);
  localparam int DW = AW / 2;

  logic [AW-1:0] r_i, r_s, r_p, r_q;
  logic [DW-1:0] t_lo, t_hi;
  logic [AW-1:0] ret_m1, s_dn, nxt_i, nxt_s, nxt_q, off_x;
  logic          push;

  always_comb begin
    push   = uop.push_hi || uop.push_lo;
    ret_m1 = r_i - AW'(1);
    s_dn   = r_s - AW'(1);
    off_x  = {{DW{mem_rdata[DW-1]}}, mem_rdata};

    mem_req   = uop.rd_opnd || push || uop.pop;
    mem_we    = push;
    mem_addr  = uop.pop ? s_dn : (push ? r_s : r_i);
    mem_wdata = uop.push_hi ? ret_m1[AW-1:DW] : ret_m1[DW-1:0];

    nxt_i = uop.rd_opnd ? r_i + AW'(1) : r_i;
    case (uop.tgt)
      T_OPND:  nxt_i = {mem_rdata, t_lo};
      T_SAVED: nxt_i = {t_hi, t_lo};
      T_RET:   nxt_i = {mem_rdata, t_lo} + AW'(1);
      T_P:     nxt_i = r_p;
      T_Q:     nxt_i = r_q;
      T_REL:   nxt_i = r_i + off_x;
      default: ;
    endcase

    nxt_s = r_s;
    if (push)         nxt_s = r_s + AW'(1);
    else if (uop.pop) nxt_s = s_dn;

    nxt_q = uop.link ? r_i : r_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_i  <= '0;
      r_s  <= '0;
      r_p  <= '0;
      r_q  <= '0;
      t_lo <= '0;
      t_hi <= '0;
    end else if (ld_fire) begin
      case (ld_sel)
        2'd0: r_i <= ld_data;
        2'd1: r_s <= ld_data;
        2'd2: r_p <= ld_data;
        default: r_q <= ld_data;
      endcase
    end else begin
      r_i <= nxt_i;
      r_s <= nxt_s;
      r_q <= nxt_q;
      if (uop.cap_lo) t_lo <= mem_rdata;
      if (uop.cap_hi) t_hi <= mem_rdata;
    end
  end

  assign reg_i = r_i;
  assign reg_s = r_s;
  assign reg_p = r_p;
  assign reg_q = r_q;

  // R6
  push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (r_s == $past(r_s) + AW'(1)));

  // R7
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uop.pop |=> (r_s == $past(r_s) - AW'(1)));

  // R6
  p_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_fire |=> $stable(r_p));
endmodule

// File: rtl/callseq_unit.sv
module callseq_unit
  import callseq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [7:0]    op_code,
  input  logic          zflag,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [AW-1:0] ld_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW/2-1:0] mem_wdata,
  input  logic [AW/2-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] reg_i,
  output logic [AW-1:0] reg_s,
  output logic [AW-1:0] reg_p,
  output logic [AW-1:0] reg_q
);
  op_kind_t          kind_dec, kind_cur;
  logic [STEP_W-1:0] step_cur;
  logic              active, ld_fire;
  uop_t              uop;

  callseq_decode u_dec (
    .op_code (op_code),
    .kind    (kind_dec)
  );

  callseq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .kind_in  (kind_dec),
    .op_ready (op_ready),
    .active   (active),
    .kind_cur (kind_cur),
    .step_cur (step_cur),
    .done     (done)
  );

  callseq_ucode u_uc (
    .en    (active),
    .kind  (kind_cur),
    .step  (step_cur),
    .zflag (zflag),
    .uop   (uop)
  );

  assign ld_fire = ld_en && op_ready && !op_valid;

  callseq_dpath #(.AW(AW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .uop       (uop),
    .ld_fire   (ld_fire),
    .ld_sel    (ld_sel),
    .ld_data   (ld_data),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .reg_i     (reg_i),
    .reg_s     (reg_s),
    .reg_p     (reg_p),
    .reg_q     (reg_q)
  );

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ready && !op_valid) |-> !mem_req);
endmodule

// File: tb/callseq_unit_tb.sv
module callseq_unit_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [7:0]  op_code = 8'h00;
  logic        zflag = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = 2'd0;
  logic [15:0] ld_data = 16'h0;
  logic        mem_req, mem_we, done;
  logic [15:0] mem_addr, reg_i, reg_s, reg_p, reg_q;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  callseq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .zflag(zflag), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_data(ld_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .reg_i(reg_i), .reg_s(reg_s), .reg_p(reg_p), .reg_q(reg_q)
  );

  // memory environment
  logic [7:0] mem [logic [15:0]];

  function automatic logic [7:0] rdm(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      else        mem_rdata <= rdm(mem_addr);
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // scoreboard items
  typedef struct {
    logic [15:0] i, s, p, q;
    int          cyc;
    string       tag;
  } st_t;
  typedef struct {
    logic [15:0] a;
    logic [7:0]  d;
  } wr_t;

  st_t exp_st[$];
  wr_t exp_wr[$];

  logic [15:0] mi = 16'h0, ms = 16'h0, mp = 16'h0, mq = 16'h0;

  // monitor
  int cnt = 0;
  bit pend = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        st_t e;
        e = exp_st.pop_front();
        chk(reg_i == e.i, e.tag, "I", {16'h0, reg_i}, {16'h0, e.i});
        chk(reg_s == e.s, e.tag, "S", {16'h0, reg_s}, {16'h0, e.s});
        chk(reg_p == e.p && reg_q == e.q, e.tag, "PQ",
            {reg_p, reg_q}, {e.p, e.q});
        pend = 1'b0;
      end
      if (op_valid && op_ready) cnt = 1;
      else                      cnt++;
      if (mem_req && mem_we) begin
        if (exp_wr.size() == 0) begin
          chk(1'b0, "R6", "unexpected write", {16'h0, mem_addr}, 32'h0);
        end else begin
          wr_t w;
          w = exp_wr.pop_front();
          chk(mem_addr == w.a && mem_wdata == w.d, "R6", "push addr/data",
              {8'h0, mem_addr, mem_wdata}, {8'h0, w.a, w.d});
        end
      end
      if (done) begin
        if (exp_st.size() == 0) begin
          chk(1'b0, "R2", "done with nothing expected", 32'h1, 32'h0);
        end else begin
          chk(cnt == exp_st[0].cyc, "R3", {"cycles ", exp_st[0].tag},
              cnt, exp_st[0].cyc);
          pend = 1'b1;
        end
      end
    end
  end

  task automatic push_wr(input logic [15:0] a, input logic [7:0] d);
    wr_t w;
    w.a = a; w.d = d;
    exp_wr.push_back(w);
  endtask

  // driver: computes expectation, then issues the opcode
  // poke: 0 none, 1 load strobe together with op_valid, 2 load strobe in first busy cycle
  task automatic run_op(input logic [7:0] oc, input logic z, input int poke);
    st_t e;
    logic [7:0]  lo, hi;
    logic [15:0] ra, t;
    string tag;
    int cyc;
    cyc = 1; tag = "R10";
    case (oc)
      8'h60, 8'h63: begin
        lo = rdm(mi); hi = rdm(mi + 16'd1);
        if (oc == 8'h63) mq = mi + 16'd2;
        mi = {hi, lo}; cyc = 3; tag = "R4";
      end
      8'h64: begin mi = mp; tag = "R5"; end
      8'h65: begin mq = mi; mi = mp; tag = "R5"; end
      8'h66: begin mi = mq; tag = "R5"; end
      8'h67: begin t = mi; mi = mq; mq = t; tag = "R5"; end
      8'hE2: begin
        lo = rdm(mi); hi = rdm(mi + 16'd1);
        ra = mi + 16'd1;
        push_wr(ms, ra[15:8]); push_wr(ms + 16'd1, ra[7:0]);
        ms = ms + 16'd2; mi = {hi, lo}; cyc = 5; tag = "R6";
      end
      8'hE4, 8'hE5: begin
        ra = mi - 16'd1;
        push_wr(ms, ra[15:8]); push_wr(ms + 16'd1, ra[7:0]);
        ms = ms + 16'd2; mi = (oc == 8'hE4) ? mp : mq; cyc = 3; tag = "R6";
      end
      8'hE1: begin
        lo = rdm(ms - 16'd1); hi = rdm(ms - 16'd2);
        ms = ms - 16'd2; mi = {hi, lo} + 16'd1; cyc = 3; tag = "R7";
      end
      8'h30, 8'h31, 8'h32: begin
        lo = rdm(mi); mi = mi + 16'd1;
        if (oc == 8'h31 || (oc == 8'h30 && !z) || (oc == 8'h32 && z))
          mi = mi + {{8{lo[7]}}, lo};
        cyc = 2; tag = "R8";
      end
      default: ;
    endcase
    if (poke != 0) tag = {tag, "/R11"};
    e.i = mi; e.s = ms; e.p = mp; e.q = mq; e.cyc = cyc; e.tag = tag;
    exp_st.push_back(e);

    @(negedge clk);
    op_code = oc; op_valid = 1'b1; zflag = z;
    if (poke == 1) begin ld_en = 1'b1; ld_sel = 2'd2; ld_data = 16'hDEAD; end
    while (!op_ready) @(negedge clk);
    @(negedge clk);
    op_valid = 1'b0; ld_en = 1'b0;
    if (poke == 2) begin
      ld_en = 1'b1; ld_sel = 2'd2; ld_data = 16'hBEEF;
      @(negedge clk);
      ld_en = 1'b0;
    end
    while (!op_ready) @(negedge clk);
  endtask

  task automatic load(input logic [1:0] sel, input logic [15:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    case (sel)
      2'd0: mi = v;
      2'd1: ms = v;
      2'd2: mp = v;
      default: mq = v;
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reg_i == 0 && reg_s == 0, "R1", "I/S after reset", {reg_i, reg_s}, 32'h0);
    chk(reg_p == 0 && reg_q == 0, "R1", "P/Q after reset", {reg_p, reg_q}, 32'h0);
    chk(op_ready && !done && !mem_req, "R1", "ready/done/req",
        {29'h0, op_ready, done, mem_req}, 32'h4);

    // R11 preload through the load port
    load(2'd0, 16'h1000); load(2'd1, 16'h0200);
    load(2'd2, 16'h2345); load(2'd3, 16'h3456);
    @(negedge clk);
    chk(reg_i == 16'h1000 && reg_s == 16'h0200, "R11", "load I/S",
        {reg_i, reg_s}, 32'h10000200);
    chk(reg_p == 16'h2345 && reg_q == 16'h3456, "R11", "load P/Q",
        {reg_p, reg_q}, 32'h23453456);

    // R4 absolute jump and link jump
    mem[16'h1000] = 8'h34; mem[16'h1001] = 8'h12;
    run_op(8'h60, 1'b0, 0);
    mem[16'h1234] = 8'h00; mem[16'h1235] = 8'h20;
    run_op(8'h63, 1'b0, 0);

    // R5 register jumps
    run_op(8'h65, 1'b0, 0);
    run_op(8'h67, 1'b0, 0);
    run_op(8'h64, 1'b0, 0);
    run_op(8'h66, 1'b0, 0);

    // R6 nested calls, R7 unwinding
    mem[reg_i] = 8'h00; mem[reg_i + 16'd1] = 8'h50;
    run_op(8'hE2, 1'b0, 0);
    run_op(8'hE5, 1'b0, 0);
    run_op(8'hE1, 1'b0, 0);
    run_op(8'hE1, 1'b0, 0);

    // R6/R7 borrow and carry across the byte boundary
    load(2'd0, 16'h3000);
    run_op(8'hE4, 1'b0, 0);
    run_op(8'hE1, 1'b0, 0);

    // R8 branches
    load(2'd0, 16'h4000);
    mem[16'h4000] = 8'hF0;
    run_op(8'h30, 1'b0, 0);                       // taken, backward
    mem[reg_i] = 8'h10; run_op(8'h30, 1'b1, 0);   // not taken
    mem[reg_i] = 8'h05; run_op(8'h32, 1'b1, 0);   // taken, forward
    mem[reg_i] = 8'h05; run_op(8'h32, 1'b0, 0);   // not taken
    mem[reg_i] = 8'h80; run_op(8'h31, 1'b1, 0);   // always, -128

    // R10 unknown opcodes
    run_op(8'h00, 1'b0, 0);
    run_op(8'hE3, 1'b0, 0);

    // R11 strobes ignored while busy or while an opcode is offered
    run_op(8'hE4, 1'b0, 2);
    run_op(8'hE1, 1'b0, 0);
    run_op(8'hFF, 1'b0, 1);

    repeat (4) @(negedge clk);
    chk(exp_st.size() == 0 && exp_wr.size() == 0, "R2", "scoreboard drained",
        exp_st.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule